// File: doc/BRIEF.md
# Successive-Approximation Converter Controller with Bus Interface

This block is the digital half of an 8-bit successive-approximation analog-to-digital converter. A processor talks to it with three active-low strobes: a select, a write that asks for a conversion, and a read that puts the result on the data bus. The analog half is outside the block. It receives the trial code on `dac_code` and returns one decision bit, `cmp_below`, which is high when the analog input lies below the level that the trial code produces.

While select and write are both low, the block holds itself in reset. Releasing either strobe arms a start. The sequence then begins on the next boundary of a free-running bit-period prescaler, which puts the first trial between one and eight clocks after the release. The bits are then decided one at a time, most significant first, each over a fixed number of clocks. When the last bit is known, the finished code is copied into an output latch and the active-low interrupt falls. A read clears the interrupt and raises the data-enable flag. A fresh start request abandons any conversion in progress.

Top module: `sar_bus_ctrl`

## Requirements
- R1: On any clock edge where `cs_n` and `wr_n` are both sampled low, the trial code is cleared to 0 and `intr_n` is driven high, even if a finished result was still unread.
- R2: The trial code stays at 0 and `intr_n` stays high for as long as `cs_n` and `wr_n` are both held low.
- R3: After the first edge at which the select/write pair is no longer both low, the trial code becomes 8'h80 between 1 and 8 clock edges later (BIT_CLKS = 8), and never at that edge itself.
- R4: Bits are decided most significant first. Each trial bit is first set to 1 and is cleared only if `cmp_below` is 1. Each bit lasts BIT_CLKS clocks, so the output latch loads the result exactly 64 edges after the first trial appears. With an ideal comparator the latched value equals the input code.
- R5: `intr_n` falls only at the clock edge where a conversion completes, which is the same edge at which the latch loads.
- R6: While `cs_n` and `rd_n` are both low, `dout_en` is 1, and the next edge returns `intr_n` to high. At all other times `dout_en` is 0.
- R7: A start request made during a conversion abandons it. `intr_n` does not fall for the abandoned conversion, the latch keeps the previous result, and a new full conversion follows.
- R8: `cmp_below` is sampled only at the last clock of each bit period. A comparator output that is wrong earlier in the period does not change the result.
- R9: With `cs_n` and `rd_n` held low the whole time, `dout` shows each new result as soon as that conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low start strobe |
| rd_n | input | 1 | Active-low read strobe |
| cmp_below | input | 1 | Comparator decision: analog input is below the current trial level |
| dac_code | output | 8 | Trial code sent to the ladder |
| dout | output | 8 | Output latch contents |
| dout_en | output | 1 | Enable for the data bus drivers |
| intr_n | output | 1 | Active-low conversion-complete interrupt |

## Verification
The checker assumes that the strobes are synchronous to `clk` and are stable for a full cycle. In particular, a select/write low period must be seen by at least one clock edge; a period shorter than a clock could be missed. The bench changes every strobe on the falling clock edge and holds each start request for two full cycles. The comparator input is driven from the bench's stored code and the current trial code. In the late-settling test it is deliberately wrong until the final clock of each bit period. The start bound is measured with a cycle counter in the checker.

// File: rtl/sar_bus_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the successive-approximation controller.
// Assumes: nothing; holds only the start-control state encoding.
package sar_bus_pkg;

    // Start-control phases: idle, held in reset, armed for start, converting
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_WAIT = 2'd2,
        ST_RUN  = 2'd3
    } ctl_state_t;

endpackage

// File: rtl/sar_start_ctl.sv
`timescale 1ns/1ps
// Module: sar_start_ctl
// Tracks the select/write reset hold and arms a start when the hold ends.
// Runs a free-running bit-period prescaler and releases the start on the
// next prescaler boundary, so the delay is 1..BIT_CLKS clocks.
// Assumes: strobes are synchronous to clk; done_p comes from the sequencer.
module sar_start_ctl
    import sar_bus_pkg::*;
#(
    parameter int BIT_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic wr_n,
    input  logic done_p,
    output logic hold,
    output logic start_p,
    output logic bit_end
);

    localparam int PH_W = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(BIT_CLKS - 1);

    ctl_state_t      state;
    logic [PH_W-1:0] phase;

    // Reset hold condition: both select and write low
    assign hold    = !cs_n && !wr_n;
    // Prescaler boundary: last clock of a bit period
    assign bit_end = (phase == PH_LAST);
    // Start fires on the first boundary after the hold ended
    assign start_p = (state == ST_WAIT) && !hold && bit_end;

    // Free-running bit-period prescaler
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (bit_end) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // Start-control state sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (hold) begin
            state <= ST_HOLD;
        end else begin
            case (state)
                ST_HOLD: state <= ST_WAIT;
                ST_WAIT: if (bit_end) state <= ST_RUN;
                ST_RUN:  if (done_p)  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sar_seq.sv
`timescale 1ns/1ps
// Module: sar_seq
// Successive-approximation register. Tries bits MSB first, one per bit
// period, and decides each bit from the comparator on the last clock of
// its period. Flags completion and presents the resolved code.
// Assumes: start_p and bit_end come from sar_start_ctl; hold overrides all.
module sar_seq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         start_p,
    input  logic         bit_end,
    input  logic         cmp_below,
    output logic [W-1:0] trial,
    output logic [W-1:0] res_code,
    output logic         busy,
    output logic         done_p
);

    localparam int IDX_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(W - 1);

    logic [IDX_W-1:0] idx;
    logic [W-1:0]     nxt;

    // Per-bit next value: resolve the current bit, set the one below it
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign nxt[i] = (IDX_W'(i) == idx) ? (trial[i] & ~cmp_below) :
                        ((idx != '0) && (IDX_W'(i) == idx - 1'b1)) ? 1'b1 :
                        trial[i];
    end

    // Completion: last bit decided at a period boundary, not overridden
    assign done_p   = busy && bit_end && (idx == '0) && !hold;
    // Resolved code offered to the output latch
    assign res_code = nxt;

    // Trial register, bit index and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            trial <= '0;
            idx   <= '0;
            busy  <= 1'b0;
        end else if (start_p) begin
            trial <= {1'b1, {(W-1){1'b0}}};
            idx   <= IDX_TOP;
            busy  <= 1'b1;
        end else if (busy && bit_end) begin
            trial <= nxt;
            if (idx == '0) begin
                busy <= 1'b0;
            end else begin
                idx <= idx - 1'b1;
            end
        end
    end

endmodule

// File: rtl/sar_out_latch.sv
`timescale 1ns/1ps
// Module: sar_out_latch
// Holds the last finished code and drives the active-low interrupt.
// Completion sets the interrupt; a read clears it; the reset hold clears it
// with top priority. A completion wins over a read at the same edge.
// Assumes: done_p is a one-cycle pulse from the sequencer.
module sar_out_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hold,
    input  logic         done_p,
    input  logic [W-1:0] res_code,
    input  logic         cs_n,
    input  logic         rd_n,
    output logic [W-1:0] dout,
    output logic         dout_en,
    output logic         intr_n
);

    logic rd_act;

    // Bus read in progress
    assign rd_act  = !cs_n && !rd_n;
    // Bus driver enable follows the read strobe directly
    assign dout_en = rd_act;

    // Result latch: loads only on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
        end else if (done_p) begin
            dout <= res_code;
        end
    end

    // Interrupt flag: hold > completion > read
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            intr_n <= 1'b1;
        end else if (done_p) begin
            intr_n <= 1'b0;
        end else if (rd_act) begin
            intr_n <= 1'b1;
        end
    end

endmodule

// File: rtl/sar_bus_ctrl.sv
`timescale 1ns/1ps
// Module: sar_bus_ctrl (top)
// Digital controller of a successive-approximation converter with an
// active-low bus interface: start handshake, bit sequencing, result latch
// and interrupt.
// Assumes: the external comparator settles within a bit period; strobes
// are synchronous to clk.
module sar_bus_ctrl #(
    parameter int W        = 8,
    parameter int BIT_CLKS = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         wr_n,
    input  logic         rd_n,
    input  logic         cmp_below,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] dout,
    output logic         dout_en,
    output logic         intr_n
);

    logic         hold_w;
    logic         start_w;
    logic         bit_end_w;
    logic         done_w;
    logic         conv_busy;
    logic [W-1:0] res_w;

    sar_start_ctl #(.BIT_CLKS(BIT_CLKS)) u_start (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .wr_n    (wr_n),
        .done_p  (done_w),
        .hold    (hold_w),
        .start_p (start_w),
        .bit_end (bit_end_w)
    );

    sar_seq #(.W(W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold_w),
        .start_p   (start_w),
        .bit_end   (bit_end_w),
        .cmp_below (cmp_below),
        .trial     (dac_code),
        .res_code  (res_w),
        .busy      (conv_busy),
        .done_p    (done_w)
    );

    sar_out_latch #(.W(W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold_w),
        .done_p   (done_w),
        .res_code (res_w),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .dout     (dout),
        .dout_en  (dout_en),
        .intr_n   (intr_n)
    );

endmodule

// File: rtl/sar_bus_chk.sv
`timescale 1ns/1ps
// Module: sar_bus_chk
// Property checker for sar_bus_ctrl, attached by bind below.
// Assumes: strobes change away from the clock edge, each stable a cycle.
module sar_bus_chk #(
    parameter int W        = 8,
    parameter int BIT_CLKS = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cs_n,
    input logic         wr_n,
    input logic         rd_n,
    input logic [W-1:0] dac_code,
    input logic [W-1:0] dout,
    input logic         intr_n,
    input logic         busy
);

    localparam int CNT_W = $clog2(BIT_CLKS + 1) + 1;

    logic             hold;
    logic             hold_q;
    logic             armed;
    logic [CNT_W-1:0] cnt;

    assign hold = !cs_n && !wr_n;

    // Measures clocks from the end of a hold to the first trial
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            armed  <= 1'b0;
            cnt    <= '0;
        end else begin
            hold_q <= hold;
            if (hold || busy) begin
                armed <= 1'b0;
            end else if (hold_q) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (armed) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_HOLD_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (intr_n && dac_code == '0));                       // R1
    AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && hold) |-> !busy);                                // R2
    AST_START_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !hold) |=> !busy);                               // R3
    AST_START_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !busy) |-> (cnt < CNT_W'(BIT_CLKS)));             // R3
    AST_LATCH_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dout) |-> ($past(busy) && !busy));                 // R4
    AST_INTR_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(intr_n) |-> $past(busy));                             // R5
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n) |=> (intr_n || $fell(intr_n)));            // R6

endmodule

bind sar_bus_ctrl sar_bus_chk #(.W(W), .BIT_CLKS(BIT_CLKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wr_n     (wr_n),
    .rd_n     (rd_n),
    .dac_code (dac_code),
    .dout     (dout),
    .intr_n   (intr_n),
    .busy     (conv_busy)
);

// File: tb/sim_sar_bus_ctrl.sv
`timescale 1ns/1ps
// Bench: vector table of input codes walked by one loop, then directed tests.
module sim_sar_bus_ctrl;

    localparam int W        = 8;
    localparam int BIT_CLKS = 8;
    localparam int NVEC     = 10;
    localparam logic [W-1:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01,
                                            8'hAA, 8'h55, 8'hC8, 8'h40, 8'h03};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cs_n = 1'b1;
    logic         wr_n = 1'b1;
    logic         rd_n = 1'b1;
    logic         cmp_below;
    logic [W-1:0] dac_code;
    logic [W-1:0] dout;
    logic         dout_en;
    logic         intr_n;

    logic [W-1:0] vin = '0;
    logic         glitch_en = 1'b0;
    logic [W-1:0] last_dac = '0;
    int           age = 0;
    int           checks = 0;
    int           fails = 0;

    always #2 clk = ~clk;

    sar_bus_ctrl #(.W(W), .BIT_CLKS(BIT_CLKS)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .cmp_below(cmp_below), .dac_code(dac_code), .dout(dout),
        .dout_en(dout_en), .intr_n(intr_n)
    );

    // Age of the current trial code in clocks, for the late-settling model
    always @(negedge clk) begin
        if (dac_code != last_dac) begin
            last_dac <= dac_code;
            age      <= 0;
        end else if (age < 15) begin
            age <= age + 1;
        end
    end

    // Ideal comparator; in glitch mode wrong until the last clock of a period
    assign cmp_below = (glitch_en && age < BIT_CLKS - 1) ? !(vin < dac_code)
                                                         : (vin < dac_code);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue_start();
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    // k = edges after the release edge until the first trial appears
    task automatic meas_start(output int k);
        k = 0;
        @(posedge clk); #1;
        while (dac_code == '0 && k < 20) begin
            @(posedge clk); #1; k++;
        end
    endtask

    // n = edges from first trial until intr_n is seen low
    task automatic wait_done(output int n);
        n = 0;
        do begin
            @(posedge clk); #1; n++;
        end while (intr_n && n < 200);
    endtask

    task automatic read_check(input logic [W-1:0] exp, input string req);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
        check(dout_en == 1'b1, "R6", dout_en, 1);
        check(dout == exp, req, dout, exp);
        @(posedge clk); #1;
        check(intr_n == 1'b1, "R6", intr_n, 1);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1; #1;
        check(dout_en == 1'b0, "R6", dout_en, 0);
    endtask

    task automatic full_conv(input logic [W-1:0] code);
        int k;
        int n;
        vin = code;
        issue_start();
        meas_start(k);
        check(k >= 1 && k <= BIT_CLKS, "R3", k, BIT_CLKS);
        check(dac_code == 8'h80, "R3", dac_code, 8'h80);
        wait_done(n);
        check(n == W * BIT_CLKS, "R4", n, W * BIT_CLKS);
        check(intr_n == 1'b0, "R5", intr_n, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int k;
        int n;
        bit ok;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // Reset state
        check(intr_n == 1'b1, "R1", intr_n, 1);
        check(dac_code == '0, "R1", dac_code, 0);
        check(dout_en == 1'b0, "R6", dout_en, 0);
        check(dout == '0, "R4", dout, 0);

        // Vector table walk: R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            repeat (i % 8 + 1) @(negedge clk);
            full_conv(VEC[i]);
            read_check(VEC[i], "R4");
        end

        // R1: hold clears an unread interrupt
        full_conv(8'h3C);
        @(negedge clk); cs_n = 1'b0; wr_n = 1'b0;
        @(posedge clk); #1;
        check(intr_n == 1'b1, "R1", intr_n, 1);
        check(dac_code == '0, "R1", dac_code, 0);
        // R2: long hold keeps the block in reset
        ok = 1'b1;
        for (int j = 0; j < 20; j++) begin
            @(posedge clk); #1;
            if (dac_code != '0 || !intr_n) ok = 1'b0;
        end
        check(ok, "R2", dac_code, 0);
        @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
        meas_start(k);
        check(k >= 1 && k <= BIT_CLKS, "R3", k, BIT_CLKS);
        wait_done(n);
        read_check(8'h3C, "R4");

        // R7: abort a running conversion
        vin = 8'h3C;
        issue_start();
        meas_start(k);
        repeat (20) @(posedge clk);
        #1;
        check(intr_n == 1'b1, "R7", intr_n, 1);
        vin = 8'hC3;
        issue_start();
        #1;
        check(intr_n == 1'b1, "R7", intr_n, 1);
        meas_start(k);
        check(k >= 1 && k <= BIT_CLKS, "R7", k, BIT_CLKS);
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; #1;
        check(dout == 8'h3C, "R7", dout, 8'h3C);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
        wait_done(n);
        check(n < W * BIT_CLKS, "R7", n, W * BIT_CLKS);
        read_check(8'hC3, "R7");

        // R8: late-settling comparator
        glitch_en = 1'b1;
        full_conv(8'h5A);
        read_check(8'h5A, "R8");
        full_conv(8'hA5);
        read_check(8'hA5, "R8");
        glitch_en = 1'b0;

        // R9: read held low throughout, start by write pulses
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        for (int j = 0; j < 2; j++) begin
            vin = (j == 0) ? 8'h81 : 8'h7E;
            @(negedge clk); wr_n = 1'b0;
            repeat (2) @(negedge clk);
            wr_n = 1'b1;
            meas_start(k);
            wait_done(n);
            check(n == W * BIT_CLKS, "R9", n, W * BIT_CLKS);
            check(dout == vin, "R9", dout, vin);
            check(dout_en == 1'b1, "R9", dout_en, 1);
            @(posedge clk); #1;
            check(intr_n == 1'b1, "R6", intr_n, 1);
        end
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule